// File: doc/BRIEF.md
# Stream width packer with carried remainder

This block takes a continuous stream of narrow words, one on every clock, and packs them into much wider words for a memory controller data bus. The wide width is not a whole multiple of the narrow width, so one narrow word can be split across two wide words. The low part of that word finishes the current wide word. The high part is kept and becomes the start of the next wide word.

Think of the input stream as one long bit string. Input word k occupies bit positions IN_W*k upward. Each wide word the block emits is the next OUT_W-bit slice of that string. A one-cycle strobe marks each finished wide word. Alongside it, a count gives the number of bits of the last input word that spilled into the following wide word. With the default widths of 168 and 576 bits, the spill count is zero once every 24 input words, and those 24 words make 7 wide words. The target clock is 200 MHz.

Top module: `gearbox_pack`

## Requirements
- R1: Every wide word with `out_valid` high equals the next consecutive OUT_W-bit slice of the input stream. Input word k sits at stream bits IN_W*k through IN_W*k+IN_W-1, and `in_data` bit 0 is the lowest of these positions.
- R2: When an input word finishes a wide word, its low bits fill the top of that wide word. Its remaining high bits become bits 0 upward of the next wide word.
- R3: With each strobe, `out_carry` gives the number of bits of the finishing input word that were carried into the next wide word. It holds its value while `out_valid` is low.
- R4: `out_valid` is high for exactly one cycle per finished wide word. `out_data` does not change while `out_valid` is low.
- R5: With the default widths, `out_carry` is zero on a strobe exactly when the number of words taken since reset is a multiple of 24.
- R6: Exactly one input word is taken on every clock edge where `rst_n` is high. Every 24 words taken after reset produce exactly 7 strobes.
- R7: `rst_n` is an active-low reset that acts on the clock edge. It empties the held remainder, sets the fill position to bit 0, and clears `out_valid`, `out_carry` and `out_data`. Words presented while `rst_n` is low are discarded, so packing after release starts at stream bit 0.
- R8: The strobe and its data appear in the cycle right after the clock edge that takes the finishing input word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, acts on the clock edge |
| in_data | input | IN_W (168) | Narrow input word, taken on every clock edge |
| out_data | output | OUT_W (576) | Packed wide word, held between strobes |
| out_valid | output | 1 | One-cycle strobe for a finished wide word |
| out_carry | output | $clog2(IN_W) (8) | Bits carried into the next wide word by the last finished one |

## Verification
The assertions rely on these conditions:
- IN_W is smaller than OUT_W.
- Every clock edge with reset released takes a real word, because the block has no gaps or stalls.
- The single-cycle strobe check also needs twice IN_W to fit within OUT_W.

The stimulus keeps to these conditions with the default widths. It drives a new word on every cycle without a break, starting on the falling edge where reset is released. It covers three alignment periods with two different data patterns. A reset in the middle of the stream is also driven on a falling edge, with words still presented during it, so that the discarded words and the restart from stream bit 0 can be seen at the output.

// File: rtl/gb_pkg.sv
// Package: shared helpers for the stream width packer.
// Assumes: only elaboration-time use (constant functions).
package gb_pkg;

    // Greatest common divisor, used to find the alignment period of two widths.
    function automatic int gb_gcd(input int a, input int b);
        int x;
        int y;
        int t;
        x = a;
        y = b;
        while (y != 0) begin
            t = x % y;
            x = y;
            y = t;
        end
        return x;
    endfunction

endpackage

// File: rtl/gb_fill_ctrl.sv
// Module: gb_fill_ctrl
// Tracks how many bits of the current wide word are already filled and decides,
// for the word arriving this cycle, whether it finishes the wide word and how
// many of its bits spill over.
// Assumes: IN_W < OUT_W and a word arrives on every cycle with rst_n high.
module gb_fill_ctrl #(
    parameter int IN_W  = 168,
    parameter int OUT_W = 576,
    parameter int FW    = $clog2(OUT_W),
    parameter int CW    = $clog2(IN_W)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [FW-1:0] fill_q,
    output logic          complete,
    output logic [CW-1:0] carry_bits
);
    localparam int SW = $clog2(OUT_W + IN_W + 1);

    logic [SW-1:0] sum;
    logic [SW-1:0] spill;

    // Purpose: bits filled after this word, and the spill if a wide word completes.
    always_comb begin
        sum        = SW'(fill_q) + SW'(IN_W);
        complete   = (sum >= SW'(OUT_W));
        spill      = sum - SW'(OUT_W);
        carry_bits = complete ? CW'(spill) : '0;
    end

    // Purpose: advance the fill position by one word, wrapping at a finished wide word.
    always_ff @(posedge clk) begin
        if (!rst_n)
            fill_q <= '0;
        else if (complete)
            fill_q <= FW'(spill);
        else
            fill_q <= FW'(sum);
    end

    AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        fill_q < FW'(OUT_W)); // R2

endmodule

// File: rtl/gb_merge.sv
// Module: gb_merge
// Shifts the incoming word up to the current fill position and ORs it onto the
// held partial word, giving OUT_W+IN_W bits of packed stream.
// Assumes: held bits at and above fill are zero.
module gb_merge #(
    parameter int IN_W  = 168,
    parameter int OUT_W = 576,
    parameter int FW    = $clog2(OUT_W)
) (
    input  logic [IN_W-1:0]       in_data,
    input  logic [OUT_W-1:0]      held,
    input  logic [FW-1:0]         fill,
    output logic [OUT_W+IN_W-1:0] merged
);
    localparam int TW = OUT_W + IN_W;

    // Purpose: place the new word right above the bits already held.
    always_comb begin
        merged = TW'(held) | (TW'(in_data) << fill);
    end

endmodule

// File: rtl/gb_out_stage.sv
// Module: gb_out_stage
// Holds the partial wide word between cycles. Registers a finished wide word
// together with its strobe and spill count.
// Assumes: complete is never high on two cycles in a row when 2*IN_W <= OUT_W.
module gb_out_stage #(
    parameter int IN_W  = 168,
    parameter int OUT_W = 576,
    parameter int CW    = $clog2(IN_W)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [OUT_W+IN_W-1:0] merged,
    input  logic                  complete,
    input  logic [CW-1:0]         carry_bits,
    output logic [OUT_W-1:0]      held_q,
    output logic [OUT_W-1:0]      out_data,
    output logic                  out_valid,
    output logic [CW-1:0]         out_carry
);
    // Purpose: keep the unfinished part of the stream; after a completion only the spill remains.
    always_ff @(posedge clk) begin
        if (!rst_n)
            held_q <= '0;
        else if (complete)
            held_q <= OUT_W'(merged[OUT_W+IN_W-1:OUT_W]);
        else
            held_q <= merged[OUT_W-1:0];
    end

    // Purpose: present a finished wide word with a one-cycle strobe, holding data otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_data  <= '0;
            out_valid <= 1'b0;
            out_carry <= '0;
        end else begin
            out_valid <= complete;
            if (complete) begin
                out_data  <= merged[OUT_W-1:0];
                out_carry <= carry_bits;
            end
        end
    end

    generate
        if (2 * IN_W <= OUT_W) begin : g_pulse_chk
            AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
                out_valid |=> !out_valid); // R4
        end
    endgenerate

    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_data)); // R4

    AST_CARRY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_carry)); // R3

endmodule

// File: rtl/gearbox_pack.sv
// Module: gearbox_pack (top)
// Packs one IN_W-bit word per clock into OUT_W-bit words, least significant end
// first, carrying the bits of a split word into the next wide word.
// Assumes: IN_W < OUT_W; no stalls, so every cycle with rst_n high carries a word.
module gearbox_pack #(
    parameter int IN_W  = 168,
    parameter int OUT_W = 576
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [IN_W-1:0]         in_data,
    output logic [OUT_W-1:0]        out_data,
    output logic                    out_valid,
    output logic [$clog2(IN_W)-1:0] out_carry
);
    import gb_pkg::*;

    localparam int FW        = $clog2(OUT_W);
    localparam int CW        = $clog2(IN_W);
    localparam int TW        = OUT_W + IN_W;
    localparam int PERIOD_IN = OUT_W / gb_gcd(IN_W, OUT_W);
    localparam int PHW       = $clog2(PERIOD_IN + 1);

    logic [FW-1:0]    fill_q;
    logic             complete;
    logic [CW-1:0]    carry_bits;
    logic [OUT_W-1:0] held_q;
    logic [TW-1:0]    merged;
    logic [PHW-1:0]   phase_q;

    gb_fill_ctrl #(.IN_W(IN_W), .OUT_W(OUT_W), .FW(FW), .CW(CW)) u_fill (
        .clk        (clk),
        .rst_n      (rst_n),
        .fill_q     (fill_q),
        .complete   (complete),
        .carry_bits (carry_bits)
    );

    gb_merge #(.IN_W(IN_W), .OUT_W(OUT_W), .FW(FW)) u_merge (
        .in_data (in_data),
        .held    (held_q),
        .fill    (fill_q),
        .merged  (merged)
    );

    gb_out_stage #(.IN_W(IN_W), .OUT_W(OUT_W), .CW(CW)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .merged     (merged),
        .complete   (complete),
        .carry_bits (carry_bits),
        .held_q     (held_q),
        .out_data   (out_data),
        .out_valid  (out_valid),
        .out_carry  (out_carry)
    );

    // Purpose: count words taken modulo the alignment period (used only by checks).
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase_q <= '0;
        else if (phase_q == PHW'(PERIOD_IN - 1))
            phase_q <= '0;
        else
            phase_q <= phase_q + 1'b1;
    end

    AST_PERIOD_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_carry == '0) == (phase_q == '0))); // R5

    AST_CARRY_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (FW'(out_carry) == fill_q)); // R3

endmodule

// File: tb/sim_gearbox_pack.sv
// Bench: bit-queue reference model of the packed stream, compared on every cycle.
module sim_gearbox_pack;
    localparam int IN_W  = 168;
    localparam int OUT_W = 576;
    localparam int CW    = $clog2(IN_W);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [IN_W-1:0]  in_data = '0;
    logic [OUT_W-1:0] out_data;
    logic             out_valid;
    logic [CW-1:0]    out_carry;

    int checks = 0;
    int fails  = 0;

    bit               q[$];
    logic [OUT_W-1:0] exp_data = '0;
    logic             exp_valid = 1'b0;
    int               exp_carry = 0;
    int               words = 0;
    int               strobes = 0;

    always #4 clk = ~clk;

    gearbox_pack #(.IN_W(IN_W), .OUT_W(OUT_W)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_data   (in_data),
        .out_data  (out_data),
        .out_valid (out_valid),
        .out_carry (out_carry)
    );

    task automatic check_bit(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic check_int(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    // One cycle: present inputs, let the edge take them, update the model, compare.
    task automatic step(input logic rst_v, input logic [IN_W-1:0] w);
        rst_n   = rst_v;
        in_data = w;
        @(posedge clk);
        if (!rst_v) begin
            q.delete();
            exp_valid = 1'b0;
            exp_carry = 0;
            exp_data  = '0;
            words     = 0;
            strobes   = 0;
        end else begin
            for (int i = 0; i < IN_W; i++) q.push_back(w[i]);
            words++;
            if (q.size() >= OUT_W) begin
                for (int i = 0; i < OUT_W; i++) exp_data[i] = q.pop_front();
                exp_valid = 1'b1;
                exp_carry = q.size();
                strobes++;
            end else begin
                exp_valid = 1'b0;
            end
        end
        @(negedge clk);
        if (!rst_v) begin
            check_bit("R7 valid in reset", out_valid, 1'b0);
            check_int("R7 carry in reset", int'(out_carry), 0);
            checks++;
            if (out_data !== '0) begin
                fails++;
                $display("FAIL R7 data in reset: got %h expected 0", out_data);
            end
        end else begin
            check_bit("R8 strobe timing", out_valid, exp_valid);
            check_int(exp_valid ? "R3 carry count" : "R3 carry hold", int'(out_carry), exp_carry);
            checks++;
            if (out_data !== exp_data) begin
                fails++;
                if (!exp_valid)
                    $display("FAIL R4 data hold: got %h expected %h", out_data, exp_data);
                else if (exp_carry != 0)
                    $display("FAIL R2 split word: got %h expected %h", out_data, exp_data);
                else
                    $display("FAIL R1 slice: got %h expected %h", out_data, exp_data);
            end
            if (out_valid)
                check_bit("R5 alignment", out_carry == '0, (words % 24) == 0);
            if ((words % 24) == 0)
                check_int("R6 strobes per period", strobes, 7 * (words / 24));
        end
    endtask

    function automatic logic [IN_W-1:0] mix_word(input int k);
        logic [31:0]  h;
        logic [191:0] r;
        h = 32'(k) * 32'h9E37_79B9 + 32'h1357_2468;
        r = {6{h}};
        return r[IN_W-1:0];
    endfunction

    initial begin
        #(8 * 5000);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        for (int i = 0; i < 3; i++) step(1'b0, IN_W'(32'hDEAD + i));
        // R1 R2 R6: incrementing words over two full alignment periods
        for (int k = 0; k < 50; k++) step(1'b1, IN_W'(k));
        // R7: reset mid-stream while words keep arriving; they must be discarded
        for (int i = 0; i < 2; i++) step(1'b0, {IN_W{1'b1}});
        // R1 R5: a scrambled pattern for a further period after restart
        for (int k = 0; k < 30; k++) step(1'b1, mix_word(k));
        for (int k = 0; k < 6; k++) step(1'b1, {IN_W{1'b1}});
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule